// File: doc/BRIEF.md
# Master Timer Trigger Output Selector

This block forms the synchronization trigger that a master timer sends to slave timers or to a converter. A three-bit source-select register picks one of eight internal sources. The sources are a software update-generate strobe (merged with a slave-reset strobe), the counter-enable level, the update-event strobe, a channel-1 capture/compare event pulse, or one of four compare reference levels. The trigger line `trgo` is registered, so it follows its source by one clock.

The block also owns the trigger-driven half of the counter enable. The counter enable is the OR of a software enable bit and the external trigger when gated mode is on. When the trigger drives the enable, one of the two paths takes an extra clock:
- With synchronization off, the trigger output lags the counter start by that clock.
- With synchronization on, the counter start is held back by that clock instead, so the slave sees the trigger aligned with the master's start.

The source register is the state machine of the block. It has eight states: `SRC_UGEN` (code 000), `SRC_ENABLE` (001), `SRC_UPDATE` (010), `SRC_CCPULSE` (011), and `SRC_REF1` to `SRC_REF4` (100 to 111). There is one transition kind, WRITE. A cycle with `mode_we` high moves from any state to the state coded by `mode_wdata`. Without a write the state holds.

Top module: `trgo_master_sel`

## Requirements
- R1: After reset the source state is `SRC_UGEN` (000), and both `trgo` and `cnt_en` are 0.
- R2: In state 000, `trgo` is high in the cycle after each cycle in which `ug_strobe` is high, and low otherwise.
- R3: In state 000, a `slv_rst_strobe` also appears on `trgo` one clock later, so the trigger lags the slave-mode reset.
- R4: `cnt_en` is high in the cycle after `cen_bit` is high. In state 001 with the trigger path idle, `trgo` follows `cen_bit` with the same one-clock latency.
- R5: With `msm_bit`=0, `gated_mode`=1 and `cen_bit`=0, a trigger high in cycle t makes `cnt_en` high at t+1. In state 001 it makes `trgo` high at t+2.
- R6: With `msm_bit`=1, `gated_mode`=1 and `cen_bit`=0, a trigger high in cycle t makes `trgo` high at t+1 (state 001) and `cnt_en` high at t+2.
- R7: With `gated_mode`=0, `trig_in` has no effect on `cnt_en` or on `trgo`.
- R8: In state 010, `trgo` is high in the cycle after each `upd_strobe` cycle.
- R9: In state 011, every cycle with `cc1_set` high gives a one-clock `trgo` pulse one clock later. This holds even back to back, so two consecutive events give two high cycles.
- R10: In states 100, 101, 110 and 111, `trgo` equals `oc_ref[0]`, `oc_ref[1]`, `oc_ref[2]` and `oc_ref[3]` respectively, delayed by one clock.
- R11: Sources that the current state does not select have no effect on `trgo`.
- R12: A write at clock edge k takes effect for `trgo` from edge k+1. Without `mode_we` the state does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_we | input | 1 | Load strobe for the source-select state |
| mode_wdata | input | 3 | New source code |
| ug_strobe | input | 1 | Software update-generate strobe |
| slv_rst_strobe | input | 1 | Counter reset caused by the trigger input in slave reset mode |
| cen_bit | input | 1 | Software counter-enable bit |
| gated_mode | input | 1 | Trigger input gates the counter enable |
| trig_in | input | 1 | Trigger input level |
| msm_bit | input | 1 | Master/slave synchronization on |
| upd_strobe | input | 1 | Update event strobe |
| cc1_set | input | 1 | Channel-1 capture/compare flag set condition |
| oc_ref | input | 4 | Compare reference levels 1 to 4 |
| trgo | output | 1 | Trigger output |
| cnt_en | output | 1 | Counter enable for the local counter |

## Verification
A wrong source state shows on `trgo` one clock after the first cycle in which the selected source and the wrongly selected one differ. A sweep over every state with mixed stimulus therefore exposes it within a few cycles. A stuck or missing trigger-delay stage shows as a one-clock misalignment between `cnt_en` and `trgo`. Which side is off depends on `msm_bit`, so the bench runs state 001 with synchronization both off and on. A write that lands one cycle early or late shows as a single wrong `trgo` cycle at the switch.

// File: rtl/trgo_pkg.sv
package trgo_pkg;
    localparam int REF_N  = 4;
    localparam int MODE_W = 3;

    typedef enum logic [MODE_W-1:0] {
        SRC_UGEN    = 3'd0,
        SRC_ENABLE  = 3'd1,
        SRC_UPDATE  = 3'd2,
        SRC_CCPULSE = 3'd3,
        SRC_REF1    = 3'd4,
        SRC_REF2    = 3'd5,
        SRC_REF3    = 3'd6,
        SRC_REF4    = 3'd7
    } trgo_src_e;
endpackage

// File: rtl/trgo_mode_fsm.sv
module trgo_mode_fsm
    import trgo_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_we,
    input  logic [MODE_W-1:0] mode_wdata,
    output trgo_src_e         state_q
);
    trgo_src_e state_d;

    // WRITE transition: any state to the coded state; otherwise hold
    always_comb begin
        state_d = state_q;
        if (mode_we) begin
            unique case (mode_wdata)
                3'd0:    state_d = SRC_UGEN;
                3'd1:    state_d = SRC_ENABLE;
                3'd2:    state_d = SRC_UPDATE;
                3'd3:    state_d = SRC_CCPULSE;
                3'd4:    state_d = SRC_REF1;
                3'd5:    state_d = SRC_REF2;
                3'd6:    state_d = SRC_REF3;
                default: state_d = SRC_REF4;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SRC_UGEN;
        else        state_q <= state_d;
    end

    AST_STATE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_we |=> $stable(state_q)); // R12
endmodule

// File: rtl/trgo_enable_path.sv
module trgo_enable_path (
    input  logic clk,
    input  logic rst_n,
    input  logic cen_bit,
    input  logic gated_mode,
    input  logic trig_in,
    input  logic msm_bit,
    output logic en_for_trgo,
    output logic cnt_en
);
    logic trig_now;
    logic trig_dly;

    assign trig_now = gated_mode & trig_in;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) trig_dly <= 1'b0;
        else        trig_dly <= trig_now;
    end

    // Sync on: trigger output takes the early copy, counter the late one.
    // Sync off: the counter takes the early copy, trigger output the late one.
    assign en_for_trgo = cen_bit | (msm_bit ? trig_now : trig_dly);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_en <= 1'b0;
        else        cnt_en <= cen_bit | (msm_bit ? trig_dly : trig_now);
    end

    AST_CEN_TO_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        cen_bit |=> cnt_en); // R4
    AST_SYNC_OFF_START: assert property (@(posedge clk) disable iff (!rst_n)
        (!msm_bit && gated_mode && trig_in) |=> cnt_en); // R5
endmodule

// File: rtl/trgo_out_mux.sv
module trgo_out_mux
    import trgo_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  trgo_src_e        state_q,
    input  logic             ug_strobe,
    input  logic             slv_rst_strobe,
    input  logic             en_for_trgo,
    input  logic             upd_strobe,
    input  logic             cc1_set,
    input  logic [REF_N-1:0] oc_ref,
    output logic             trgo
);
    logic trgo_d;

    always_comb begin
        unique case (state_q)
            SRC_UGEN:    trgo_d = ug_strobe | slv_rst_strobe;
            SRC_ENABLE:  trgo_d = en_for_trgo;
            SRC_UPDATE:  trgo_d = upd_strobe;
            SRC_CCPULSE: trgo_d = cc1_set;
            SRC_REF1:    trgo_d = oc_ref[0];
            SRC_REF2:    trgo_d = oc_ref[1];
            SRC_REF3:    trgo_d = oc_ref[2];
            SRC_REF4:    trgo_d = oc_ref[3];
            default:     trgo_d = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) trgo <= 1'b0;
        else        trgo <= trgo_d;
    end

    AST_UG_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SRC_UGEN && ug_strobe) |=> trgo); // R2
    AST_SLAVE_RST_LAG: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SRC_UGEN && slv_rst_strobe) |=> trgo); // R3
    AST_UPDATE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SRC_UPDATE) |=> (trgo == $past(upd_strobe))); // R8
    AST_CC_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SRC_CCPULSE && cc1_set) |=> trgo); // R9
    AST_REF_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        state_q[2] |=> (trgo == $past(oc_ref[state_q[1:0]]))); // R10
endmodule

// File: rtl/trgo_master_sel.sv
module trgo_master_sel
    import trgo_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_we,
    input  logic [2:0]       mode_wdata,
    input  logic             ug_strobe,
    input  logic             slv_rst_strobe,
    input  logic             cen_bit,
    input  logic             gated_mode,
    input  logic             trig_in,
    input  logic             msm_bit,
    input  logic             upd_strobe,
    input  logic             cc1_set,
    input  logic [3:0]       oc_ref,
    output logic             trgo,
    output logic             cnt_en
);
    trgo_src_e state_q;
    logic      en_for_trgo;

    trgo_mode_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_we    (mode_we),
        .mode_wdata (mode_wdata),
        .state_q    (state_q)
    );

    trgo_enable_path u_en (
        .clk         (clk),
        .rst_n       (rst_n),
        .cen_bit     (cen_bit),
        .gated_mode  (gated_mode),
        .trig_in     (trig_in),
        .msm_bit     (msm_bit),
        .en_for_trgo (en_for_trgo),
        .cnt_en      (cnt_en)
    );

    trgo_out_mux u_mux (
        .clk            (clk),
        .rst_n          (rst_n),
        .state_q        (state_q),
        .ug_strobe      (ug_strobe),
        .slv_rst_strobe (slv_rst_strobe),
        .en_for_trgo    (en_for_trgo),
        .upd_strobe     (upd_strobe),
        .cc1_set        (cc1_set),
        .oc_ref         (oc_ref),
        .trgo           (trgo)
    );

    AST_RESET_QUIET: assert property (@(posedge clk)
        $rose(rst_n) |-> (!trgo && !cnt_en)); // R1
endmodule

// File: tb/tb_trgo_master_sel.sv
module tb_trgo_master_sel;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_we = 1'b0;
    logic [2:0] mode_wdata = 3'd0;
    logic       ug_strobe = 1'b0, slv_rst_strobe = 1'b0, cen_bit = 1'b0;
    logic       gated_mode = 1'b0, trig_in = 1'b0, msm_bit = 1'b0;
    logic       upd_strobe = 1'b0, cc1_set = 1'b0;
    logic [3:0] oc_ref = 4'd0;
    logic       trgo, cnt_en;

    int checks = 0;
    int failures = 0;
    logic [2:0] m_mode = 3'd0;
    logic       m_trig_q = 1'b0;
    bit         done = 1'b0;

    always #10 clk = ~clk;

    trgo_master_sel dut (
        .clk(clk), .rst_n(rst_n), .mode_we(mode_we), .mode_wdata(mode_wdata),
        .ug_strobe(ug_strobe), .slv_rst_strobe(slv_rst_strobe), .cen_bit(cen_bit),
        .gated_mode(gated_mode), .trig_in(trig_in), .msm_bit(msm_bit),
        .upd_strobe(upd_strobe), .cc1_set(cc1_set), .oc_ref(oc_ref),
        .trgo(trgo), .cnt_en(cnt_en)
    );

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b t=%0t", req, act, exp, $time);
        end
    endtask

    function automatic string trgo_tag(input logic [2:0] m, input logic s);
        case (m)
            3'd0: return "R2";
            3'd1: return s ? "R6" : "R5";
            3'd2: return "R8";
            3'd3: return "R9";
            default: return "R10";
        endcase
    endfunction

    // Inputs set just after a falling edge; model one rising edge; check at next falling edge
    task automatic step(input string t_tag, input string c_tag);
        logic tg, e_trgo, e_cnt;
        tg = gated_mode & trig_in;
        e_cnt = cen_bit | (msm_bit ? m_trig_q : tg);
        case (m_mode)
            3'd0: e_trgo = ug_strobe | slv_rst_strobe;
            3'd1: e_trgo = cen_bit | (msm_bit ? tg : m_trig_q);
            3'd2: e_trgo = upd_strobe;
            3'd3: e_trgo = cc1_set;
            default: e_trgo = oc_ref[m_mode - 3'd4];
        endcase
        m_trig_q = tg;
        if (mode_we) m_mode = mode_wdata;
        @(posedge clk);
        @(negedge clk);
        check(t_tag, trgo, e_trgo);
        check(c_tag, cnt_en, e_cnt);
    endtask

    task automatic clear_in();
        mode_we = 0; ug_strobe = 0; slv_rst_strobe = 0; cen_bit = 0;
        gated_mode = 0; trig_in = 0; upd_strobe = 0; cc1_set = 0; oc_ref = 0;
    endtask

    task automatic write_mode(input logic [2:0] m);
        clear_in();
        mode_we = 1; mode_wdata = m;
        step("R12", "R4");
        mode_we = 0;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", trgo, 1'b0);
        check("R1", cnt_en, 1'b0);
        // R1: state 000 after reset, so an update-generate strobe is selected
        ug_strobe = 1; step("R1", "R4");
        ug_strobe = 0; step("R2", "R4");
        // R3: slave-mode reset lags onto trgo
        slv_rst_strobe = 1; step("R3", "R4");
        slv_rst_strobe = 0; step("R3", "R4");

        // Sweep every state, both sync settings, mixed stimulus
        for (int m = 0; m < 8; m++) begin
            for (int s = 0; s < 2; s++) begin
                write_mode(3'(m));
                msm_bit = s[0];
                for (int k = 0; k < 120; k++) begin
                    logic [31:0] r;
                    r = $urandom;
                    ug_strobe = r[0]; slv_rst_strobe = r[1] & r[2];
                    cen_bit = r[3] & r[4] & r[5]; gated_mode = r[6] | r[7];
                    trig_in = r[8]; upd_strobe = r[9]; cc1_set = r[10];
                    oc_ref = r[14:11];
                    step(trgo_tag(3'(m), s[0]), "R4");
                end
            end
        end

        // R5: sync off, trigger-driven start
        write_mode(3'd1);
        msm_bit = 0; gated_mode = 1; trig_in = 1; step("R5", "R5");
        trig_in = 0; step("R5", "R5");
        step("R5", "R5");
        // R6: sync on
        msm_bit = 1; trig_in = 1; step("R6", "R6");
        trig_in = 0; step("R6", "R6");
        step("R6", "R6");
        // R7: trigger ignored without gated mode
        gated_mode = 0;
        for (int k = 0; k < 6; k++) begin
            trig_in = k[0]; msm_bit = k[1];
            step("R7", "R7");
        end
        // R9: back-to-back capture events each pulse
        write_mode(3'd3);
        cc1_set = 1; step("R9", "R4");
        step("R9", "R4");
        cc1_set = 0; step("R9", "R4");
        // R11: unselected sources idle the output in state 100
        write_mode(3'd4);
        for (int k = 0; k < 8; k++) begin
            ug_strobe = 1; upd_strobe = 1; cc1_set = 1; oc_ref = 4'b1110;
            slv_rst_strobe = 1; step("R11", "R4");
        end
        // R12: write at the same edge as a strobe uses the old state
        clear_in(); oc_ref = 4'b0001;
        mode_we = 1; mode_wdata = 3'd2; upd_strobe = 1; step("R12", "R4");
        mode_we = 0; upd_strobe = 1; oc_ref = 4'b0000; step("R12", "R4");
        upd_strobe = 0; step("R12", "R4");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule